// File: doc/BRIEF.md
# External Memory Area Decoder with Wait-State Timing

This block sits between a processor's bus unit and its external memory pins. Each access request carries a 32-bit physical address. The block finds which of three fixed 64-Mbyte areas the address falls in and drives that area's active-low chip select. It also drives an output-enable style read strobe, or one write strobe per byte lane. For the whole access it reports the data bus width configured for that area.

Each access lasts one cycle plus the programmed wait count of its area. In the area with the longest wait field, an external active-low wait input can stretch the access further. The bus unit sees a one-cycle `done_o` pulse in the last cycle of every access. Addresses outside the three areas finish at once with `err_o` and drive no pins.

The third area can be put into a card mode. In that mode its lower half is a memory-card window and its upper half is an I/O-card window, and only byte or word width is allowed.

Top module: `mem_area_ctl`

## Requirements
- R1: After reset, `cs_n_o` is 3'b111, `rd_n_o` is 1, `we_n_o` is 4'hF, `width_o` is 0, and `done_o`, `err_o`, `card_mem_o` and `card_io_o` are 0.
- R2: Address bits 28..26 select the area. Code 3'b011 drives `cs_n_o[0]` low, 3'b100 drives `cs_n_o[1]` low and 3'b101 drives `cs_n_o[2]` low. Bits 31..29 are ignored, so every area repeats every 0x20000000.
- R3: A request is accepted on a clock edge while the block is idle. The chip select and strobe are asserted from the next cycle through the last cycle of the access. An access with N wait cycles and no external wait lasts N+1 cycles.
- R4: Areas 3 and 5 each take their wait count, 0 to 3, from a 2-bit field (`a3_wait_i`, `a5_wait_i`).
- R5: Area 4 takes its wait count from a 4-bit field `a4_wait_i` with a range of 0 to 10. Codes 11 to 15 give 10 wait cycles.
- R6: During an area 4 access, `wait_n_i` low in the last programmed cycle holds the access, and it ends in the first cycle where `wait_n_i` is high. In areas 3 and 5, `wait_n_i` has no effect.
- R7: A read (`wr_i`=0) drives `rd_n_o` low and all of `we_n_o` high. A write drives `rd_n_o` high and drives `we_n_o[i]` low exactly where `be_i[i]`=1.
- R8: During an access, `width_o` carries the selected area's 2-bit width field (0 byte, 1 word, 2 longword, 3 passed through unchanged). When idle it is 0.
- R9: With `card_mode_i`=1, an area 5 access raises `card_mem_o` when address bit 25 is 0 and `card_io_o` when it is 1. In this mode, width codes 2 and 3 are reported as 1. Outside card mode, or in other areas, both flags stay 0.
- R10: An address whose area code is not 3, 4 or 5 asserts no chip select and no strobe. It completes in the cycle after acceptance with `done_o` and `err_o` both high for that one cycle.
- R11: `done_o` is high for exactly one cycle, the last cycle of each access.
- R12: A request raised while an access is in progress is ignored and does not change the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| addr_i | input | 32 | Physical address |
| wr_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte-lane enables for writes |
| card_mode_i | input | 1 | Area 5 card mode |
| a3_wait_i | input | 2 | Area 3 wait count |
| a4_wait_i | input | 4 | Area 4 wait count |
| a5_wait_i | input | 2 | Area 5 wait count |
| a3_width_i | input | 2 | Area 3 width code |
| a4_width_i | input | 2 | Area 4 width code |
| a5_width_i | input | 2 | Area 5 width code |
| wait_n_i | input | 1 | External wait, active low |
| cs_n_o | output | 3 | Chip selects, bit 0 = area 3 |
| rd_n_o | output | 1 | Read strobe / output enable |
| we_n_o | output | 4 | Per-lane write strobes |
| width_o | output | 2 | Width code of the current access |
| card_mem_o | output | 1 | Memory-card window access |
| card_io_o | output | 1 | I/O-card window access |
| done_o | output | 1 | Last cycle of access |
| err_o | output | 1 | Unmapped address completion |

## Verification
Several properties are checked on every cycle by assertions. At most one chip select is low at a time, and a strobe never appears without a chip select. Pins stay stable until `done_o`, and `done_o` never lasts two cycles. An error completion drives no chip select. A low wait input keeps an area 4 access alive, and card-mode widths never report longword. The cycle-exact access length for each wait code is shown only by the bench's reference model and scenarios. The same holds for the clamp of large area 4 codes, shadow-address decode, byte-lane write patterns and the discarding of requests raised mid-access.

// File: rtl/mem_area_pkg.sv
package mem_area_pkg;

  typedef enum logic [1:0] {
    AR_NONE = 2'd0,
    AR_3    = 2'd1,
    AR_4    = 2'd2,
    AR_5    = 2'd3
  } area_e;

  localparam logic [2:0] CODE_AREA3 = 3'b011;
  localparam logic [2:0] CODE_AREA4 = 3'b100;
  localparam logic [2:0] CODE_AREA5 = 3'b101;

  localparam logic [1:0] WID_WORD = 2'd1;

endpackage

// File: rtl/area_decode.sv
module area_decode
  import mem_area_pkg::*;
#(
  parameter int A3_WAIT_W   = 2,
  parameter int A4_WAIT_W   = 4,
  parameter int A5_WAIT_W   = 2,
  parameter int A4_WAIT_MAX = 10,
  parameter int CNT_W       = 4
) (
  input  logic [3:0]           sel_i,
  input  logic                 card_mode_i,
  input  logic [A3_WAIT_W-1:0] a3_wait_i,
  input  logic [A4_WAIT_W-1:0] a4_wait_i,
  input  logic [A5_WAIT_W-1:0] a5_wait_i,
  input  logic [1:0]           a3_width_i,
  input  logic [1:0]           a4_width_i,
  input  logic [1:0]           a5_width_i,
  output area_e                area_o,
  output logic [CNT_W-1:0]     wait_cnt_o,
  output logic [1:0]           width_o,
  output logic                 card_mem_o,
  output logic                 card_io_o
);

  // sel_i[3:1] is the area code, sel_i[0] the half-of-area bit
  logic [2:0] code;
  logic       upper_half;

  assign code       = sel_i[3:1];
  assign upper_half = sel_i[0];

  always_comb begin
    area_o     = AR_NONE;
    wait_cnt_o = '0;
    width_o    = '0;
    card_mem_o = 1'b0;
    card_io_o  = 1'b0;
    unique case (code)
      CODE_AREA3: begin
        area_o     = AR_3;
        wait_cnt_o = CNT_W'(a3_wait_i);
        width_o    = a3_width_i;
      end
      CODE_AREA4: begin
        area_o  = AR_4;
        width_o = a4_width_i;
        if (int'(a4_wait_i) > A4_WAIT_MAX) wait_cnt_o = CNT_W'(A4_WAIT_MAX);
        else                               wait_cnt_o = CNT_W'(a4_wait_i);
      end
      CODE_AREA5: begin
        area_o     = AR_5;
        wait_cnt_o = CNT_W'(a5_wait_i);
        if (card_mode_i) begin
          width_o    = a5_width_i[1] ? WID_WORD : a5_width_i;
          card_mem_o = !upper_half;
          card_io_o  = upper_half;
        end else begin
          width_o = a5_width_i;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wait_seq.sv
module wait_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             hold_i,
  output logic             busy_o,
  output logic             last_o
);

  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d  = S_RUN;
          cnt_d = load_i;
        end
      end
      S_RUN: begin
        if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
        else if (!hold_i) st_d  = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (st_q == S_RUN);
  assign last_o = busy_o && (cnt_q == '0) && !hold_i;

  // R6: a held access stays running into the next cycle
  a_r6_hold_keeps_busy: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && hold_i) |=> busy_o);

endmodule

// File: rtl/mem_area_ctl.sv
module mem_area_ctl
  import mem_area_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int AREA_LSB    = 26,
  parameter int A3_WAIT_W   = 2,
  parameter int A4_WAIT_W   = 4,
  parameter int A5_WAIT_W   = 2,
  parameter int A4_WAIT_MAX = 10,
  parameter int LANES       = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [LANES-1:0]     be_i,
  input  logic                 card_mode_i,
  input  logic [A3_WAIT_W-1:0] a3_wait_i,
  input  logic [A4_WAIT_W-1:0] a4_wait_i,
  input  logic [A5_WAIT_W-1:0] a5_wait_i,
  input  logic [1:0]           a3_width_i,
  input  logic [1:0]           a4_width_i,
  input  logic [1:0]           a5_width_i,
  input  logic                 wait_n_i,
  output logic [2:0]           cs_n_o,
  output logic                 rd_n_o,
  output logic [LANES-1:0]     we_n_o,
  output logic [1:0]           width_o,
  output logic                 card_mem_o,
  output logic                 card_io_o,
  output logic                 done_o,
  output logic                 err_o
);

  localparam int A3_MAX   = (1 << A3_WAIT_W) - 1;
  localparam int A5_MAX   = (1 << A5_WAIT_W) - 1;
  localparam int MAX_35   = (A3_MAX > A5_MAX) ? A3_MAX : A5_MAX;
  localparam int WAIT_MAX = (A4_WAIT_MAX > MAX_35) ? A4_WAIT_MAX : MAX_35;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam int SEL_LSB  = AREA_LSB - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr_i[ADDR_W-1:AREA_LSB+3], addr_i[SEL_LSB-1:0]};

  // decode of the incoming address
  area_e            dec_area;
  logic [CNT_W-1:0] dec_wait;
  logic [1:0]       dec_width;
  logic             dec_cmem, dec_cio;

  area_decode #(
    .A3_WAIT_W  (A3_WAIT_W),
    .A4_WAIT_W  (A4_WAIT_W),
    .A5_WAIT_W  (A5_WAIT_W),
    .A4_WAIT_MAX(A4_WAIT_MAX),
    .CNT_W      (CNT_W)
  ) u_decode (
    .sel_i      (addr_i[AREA_LSB+2:SEL_LSB]),
    .card_mode_i(card_mode_i),
    .a3_wait_i  (a3_wait_i),
    .a4_wait_i  (a4_wait_i),
    .a5_wait_i  (a5_wait_i),
    .a3_width_i (a3_width_i),
    .a4_width_i (a4_width_i),
    .a5_width_i (a5_width_i),
    .area_o     (dec_area),
    .wait_cnt_o (dec_wait),
    .width_o    (dec_width),
    .card_mem_o (dec_cmem),
    .card_io_o  (dec_cio)
  );

  // access timing
  logic busy, last, accept, hold;
  area_e area_q;

  assign accept = req_i && !busy;
  assign hold   = (area_q == AR_4) && !wait_n_i;

  wait_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_n_i(rst_n),
    .start_i(accept),
    .load_i (dec_wait),
    .hold_i (hold),
    .busy_o (busy),
    .last_o (last)
  );

  // access attributes captured with an explicit clock enable
  logic             wr_q, cmem_q, cio_q;
  logic [LANES-1:0] be_q;
  logic [1:0]       width_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      area_q  <= AR_NONE;
      wr_q    <= 1'b0;
      be_q    <= '0;
      width_q <= '0;
      cmem_q  <= 1'b0;
      cio_q   <= 1'b0;
    end else if (accept) begin
      area_q  <= dec_area;
      wr_q    <= wr_i;
      be_q    <= be_i;
      width_q <= dec_width;
      cmem_q  <= dec_cmem;
      cio_q   <= dec_cio;
    end
  end

  // pin drive
  logic active;
  assign active = busy && (area_q != AR_NONE);

  for (genvar g = 0; g < 3; g++) begin : g_cs
    assign cs_n_o[g] = !(busy && (area_q == area_e'(g + 1)));
  end

  assign rd_n_o     = !(active && !wr_q);
  assign we_n_o     = (active && wr_q) ? ~be_q : '1;
  assign width_o    = busy ? width_q : '0;
  assign card_mem_o = busy && cmem_q;
  assign card_io_o  = busy && cio_q;
  assign done_o     = last;
  assign err_o      = busy && (area_q == AR_NONE);

  // R2: never more than one chip select at a time
  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(~cs_n_o));

  // R7: strobes only together with a chip select
  a_r7_strobe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!rd_n_o || we_n_o != '1) |-> (cs_n_o != 3'b111));

  // R3: pins held steady until the final cycle
  a_r3_pins_held: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cs_n_o != 3'b111 && !done_o) |=>
      ($stable(cs_n_o) && $stable(rd_n_o) && $stable(we_n_o)));

  // R11: done lasts a single cycle
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);

  // R10: error completion drives no chip select
  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_o |-> (done_o && cs_n_o == 3'b111));

  // R6: a low wait input keeps an area 4 access alive
  a_r6_wait_extends: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!cs_n_o[1] && !wait_n_i) |=> !cs_n_o[1]);

  // R9: card windows never report longword width
  a_r9_card_width: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (card_mem_o || card_io_o) |-> (!cs_n_o[2] && !width_o[1]));

endmodule

// File: tb/mem_area_ctl_test.sv
module mem_area_ctl_test;

  logic        clk_i = 1'b0;
  logic        rst_n_i = 1'b0;
  logic        req_i, wr_i, card_mode_i, wait_n_i;
  logic [31:0] addr_i;
  logic [3:0]  be_i, a4_wait_i;
  logic [1:0]  a3_wait_i, a5_wait_i, a3_width_i, a4_width_i, a5_width_i;
  logic [2:0]  cs_n_o;
  logic        rd_n_o, card_mem_o, card_io_o, done_o, err_o;
  logic [3:0]  we_n_o;
  logic [1:0]  width_o;

  mem_area_ctl uut (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .req_i(req_i), .addr_i(addr_i),
    .wr_i(wr_i), .be_i(be_i), .card_mode_i(card_mode_i),
    .a3_wait_i(a3_wait_i), .a4_wait_i(a4_wait_i), .a5_wait_i(a5_wait_i),
    .a3_width_i(a3_width_i), .a4_width_i(a4_width_i), .a5_width_i(a5_width_i),
    .wait_n_i(wait_n_i), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .we_n_o(we_n_o),
    .width_o(width_o), .card_mem_o(card_mem_o), .card_io_o(card_io_o),
    .done_o(done_o), .err_o(err_o)
  );

  always #5 clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  bit   m_busy = 0;
  int   m_cnt = 0, m_area = 0, m_width = 0, m_settle = 0;
  bit   m_wr = 0, m_card = 0, m_hi = 0;
  logic [3:0] m_be = 4'h0;

  always @(posedge clk_i) begin
    if (!rst_n_i) begin
      m_busy = 0; m_settle = 2;
    end else if (m_settle > 0) begin
      m_settle--;
    end else if (m_busy) begin
      if (m_cnt > 0) m_cnt--;
      else if (!(m_area == 4 && !wait_n_i)) m_busy = 0;
    end else if (req_i) begin
      m_busy = 1;
      m_wr = wr_i; m_be = be_i; m_hi = addr_i[25]; m_card = card_mode_i;
      case (addr_i[28:26])
        3'd3: begin m_area = 3; m_cnt = a3_wait_i; m_width = a3_width_i; end
        3'd4: begin m_area = 4; m_cnt = (a4_wait_i > 10) ? 10 : a4_wait_i; m_width = a4_width_i; end
        3'd5: begin
          m_area = 5; m_cnt = a5_wait_i;
          m_width = (card_mode_i && a5_width_i >= 2) ? 1 : a5_width_i;
        end
        default: begin m_area = 0; m_cnt = 0; m_width = 0; end
      endcase
    end
  end

  // per-cycle comparison, sampled 2 ns after the falling edge
  int cur_len = 0, last_len = -1;

  always begin
    @(negedge clk_i);
    #2;
    if (rst_n_i) begin
      logic [2:0] e_cs;
      bit e_act, e_done;
      e_act = m_busy && m_area != 0;
      e_cs = 3'b111;
      if (e_act) e_cs[m_area-3] = 1'b0;
      e_done = m_busy && m_cnt == 0 && !(m_area == 4 && !wait_n_i);
      chk(cs_n_o == e_cs, "R2", "cs_n", cs_n_o, e_cs);
      chk(rd_n_o == !(e_act && !m_wr), "R7", "rd_n", rd_n_o, !(e_act && !m_wr));
      chk(we_n_o == ((e_act && m_wr) ? ~m_be : 4'hF), "R7", "we_n", we_n_o,
          (e_act && m_wr) ? ~m_be : 4'hF);
      chk(width_o == (m_busy ? m_width : 0), "R8", "width", width_o, m_busy ? m_width : 0);
      chk(card_mem_o == (m_busy && m_area == 5 && m_card && !m_hi), "R9", "card_mem",
          card_mem_o, m_busy && m_area == 5 && m_card && !m_hi);
      chk(card_io_o == (m_busy && m_area == 5 && m_card && m_hi), "R9", "card_io",
          card_io_o, m_busy && m_area == 5 && m_card && m_hi);
      chk(done_o == e_done, "R11", "done", done_o, e_done);
      chk(err_o == (m_busy && m_area == 0), "R10", "err", err_o, m_busy && m_area == 0);
      if (cs_n_o != 3'b111) cur_len++;
      if (done_o) begin last_len = cur_len; cur_len = 0; end
    end
  end

  // one access; hold = cycles of external wait, intrude = cycle of a stray request
  task automatic access(input logic [31:0] a, input bit w, input logic [3:0] b,
                        input int hold, input int intrude);
    int k;
    @(negedge clk_i);
    addr_i = a; wr_i = w; be_i = b; req_i = 1'b1;
    wait_n_i = (hold > 0) ? 1'b0 : 1'b1;
    k = 0;
    forever begin
      @(negedge clk_i);
      k++;
      if (!m_busy && k > 1) break;
      req_i = (intrude != 0 && k == intrude);
      if (req_i) begin addr_i = 32'h0C000040; wr_i = 1'b1; end
      if (k >= hold) wait_n_i = 1'b1;
    end
    req_i = 1'b0; wait_n_i = 1'b1;
  endtask

  initial begin
    #2000000;
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    if (!finished) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_i = 0; wr_i = 0; be_i = 4'hF; addr_i = 0; card_mode_i = 0; wait_n_i = 1;
    a3_wait_i = 0; a4_wait_i = 0; a5_wait_i = 0;
    a3_width_i = 0; a4_width_i = 0; a5_width_i = 0;
    repeat (3) @(negedge clk_i);
    // R1: idle pins under reset
    chk(cs_n_o == 3'b111 && rd_n_o && we_n_o == 4'hF, "R1", "reset pins",
        {cs_n_o, rd_n_o, we_n_o}, 8'hFF);
    chk(!done_o && !err_o && width_o == 0 && !card_mem_o && !card_io_o, "R1",
        "reset flags", {done_o, err_o, width_o, card_mem_o, card_io_o}, 0);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);

    // R4 R2: area 3 read, two wait cycles
    a3_wait_i = 2; a3_width_i = 1;
    access(32'h0C000010, 0, 4'hF, 0, 0);
    chk(last_len == 3, "R4", "area3 length", last_len, 3);
    // R2: shadow copy of area 3, write with sparse lanes
    access(32'hEC000000, 1, 4'b0101, 0, 0);
    chk(last_len == 3, "R2", "shadow length", last_len, 3);
    // R3: zero wait gives one cycle
    a3_wait_i = 0;
    access(32'h0FFFFFFC, 1, 4'b1000, 0, 0);
    chk(last_len == 1, "R3", "zero-wait length", last_len, 1);

    // R5: area 4 counts and clamp
    a4_width_i = 2;
    a4_wait_i = 5;  access(32'h10000000, 0, 4'hF, 0, 0);
    chk(last_len == 6, "R5", "area4 wait5", last_len, 6);
    a4_wait_i = 10; access(32'h33FFFFF0, 1, 4'b0011, 0, 0);
    chk(last_len == 11, "R5", "area4 wait10", last_len, 11);
    a4_wait_i = 15; access(32'h50000000, 0, 4'hF, 0, 0);
    chk(last_len == 11, "R5", "area4 clamp15", last_len, 11);
    a4_wait_i = 11; access(32'h10000004, 0, 4'hF, 0, 0);
    chk(last_len == 11, "R5", "area4 clamp11", last_len, 11);

    // R6: external wait stretches area 4 only
    a4_wait_i = 1;
    access(32'h10000008, 0, 4'hF, 5, 0);
    chk(last_len == 5, "R6", "area4 external wait", last_len, 5);
    access(32'h0C000008, 0, 4'hF, 5, 0);
    chk(last_len == 1, "R6", "area3 ignores wait", last_len, 1);
    a5_wait_i = 1;
    access(32'h14000000, 0, 4'hF, 4, 0);
    chk(last_len == 2, "R6", "area5 ignores wait", last_len, 2);

    // R9 R8: area 5 widths and card windows
    a5_width_i = 2; a5_wait_i = 3;
    access(32'h14000100, 1, 4'b1100, 0, 0);
    chk(last_len == 4, "R4", "area5 wait3", last_len, 4);
    card_mode_i = 1; a5_width_i = 3;
    access(32'h14000000, 0, 4'hF, 0, 0);
    access(32'hF6000000, 1, 4'b0001, 0, 0);
    a5_width_i = 0;
    access(32'h17FFFFFC, 0, 4'hF, 0, 0);
    card_mode_i = 0;
    access(32'h16000000, 0, 4'hF, 0, 0);

    // R10: unmapped area codes
    access(32'h00000000, 0, 4'hF, 0, 0);
    chk(last_len == 0, "R10", "code0 no cs", last_len, 0);
    access(32'h1C000000, 1, 4'hF, 0, 0);
    chk(last_len == 0, "R10", "code7 no cs", last_len, 0);
    access(32'h08000000, 0, 4'hF, 0, 0);
    chk(last_len == 0, "R10", "code2 no cs", last_len, 0);

    // R12: stray request during an area 4 access
    a4_wait_i = 8;
    access(32'h10000020, 0, 4'hF, 0, 3);
    chk(last_len == 9, "R12", "stray request ignored", last_len, 9);
    repeat (3) @(negedge clk_i);
    chk(cs_n_o == 3'b111, "R12", "no follow-on access", cs_n_o, 7);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule